// File: doc/BRIEF.md
# Captured Pulse Parameter Extractor

This block measures one pulse held in a captured record of samples. After a start strobe, samples arrive one per clock with a valid flag. A last marker closes the record. The block keeps the record in an internal buffer and reads it twice.

During the first pass, as the samples stream in, it finds the highest sample and its index. In the same pass it adds up the samples that fall inside a programmable averaging window. During the second pass it reads the stored record back and finds where the signal crosses 10%, 50% and 90% of the span between a baseline and the peak.

From those crossings it derives the rise time, the pulse width and the fall time. One sample stands for one nanosecond, so every time result is a count of samples. All results appear together with a single-cycle done strobe and stay there until the next record finishes. A result whose crossing cannot be found reads as all ones and raises its own invalid flag.

Top module: `pulse_param_extract`

## Requirements
- R1: A high `startIn` in any state discards the current record and opens a new one. While the record is open, each cycle with `sampleValid` high stores `sampleData` at the next index, starting at 0. `sampleValid` with `sampleLast` closes the record. Samples offered while no record is open are ignored. Only the first DEPTH (256) samples are stored; later ones are dropped until the last marker arrives.
- R2: `peakOut` is the largest stored sample. `peakIdxOut` is its index; when several samples share that value, the lowest index is reported.
- R3: The amplitude A is peak minus baseline, or 0 if the peak is not above the baseline. The three thresholds are truncated integers:
  - T10 = baseline + floor(A/10)
  - T50 = baseline + floor(A/2)
  - T90 = baseline + floor(9A/10)
- R4: Rise is measured on the samples at or before the peak index. A is the first index there with sample >= T10, and B is the first with sample >= T90. `riseOut` = B - A. If either index is missing, `riseOut` is all ones and `riseBad` is 1.
- R5: Width runs from a start index to an end index:
  - the start is the first index at or before the peak with sample >= T50;
  - the end is the first index after the peak with sample < T50.
  `widthOut` = end - start. If either index is missing, `widthOut` is all ones and `widthBad` is 1.
- R6: Fall is measured on the samples after the peak index. A is the first index there with sample < T90, and B is the first with sample < T10. `fallOut` = B - A. If either index is missing, `fallOut` is all ones and `fallBad` is 1.
- R7: The averaging window starts at index `winStart` and is 2^L samples long, where L is `winLog2` limited to at most 10. Window positions beyond the stored record count as zero. `avgOut` = floor(window sum / 2^L).
- R8: `baseline`, `winStart` and `winLog2` are sampled in the cycle `startIn` is high. Later changes have no effect on that record.
- R9: `doneOut` is high for exactly one cycle, N rising edges after the edge that accepted the last sample, where N is the number of stored samples. All results change only at that strobe and hold until the next one.
- R10: While `rstN` is low, `doneOut`, all results and all invalid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Opens a new record, samples the configuration |
| sampleValid | input | 1 | Sample present this cycle |
| sampleData | input | 8 | Sample value |
| sampleLast | input | 1 | Marks the final sample of the record |
| baseline | input | 8 | Baseline level for the thresholds |
| winStart | input | 8 | First index of the averaging window |
| winLog2 | input | 4 | log2 of the window length, limited to 10 |
| doneOut | output | 1 | One-cycle result strobe |
| peakOut | output | 8 | Peak sample value |
| peakIdxOut | output | 8 | Index of the peak |
| widthOut | output | 8 | Width at half level, in samples |
| riseOut | output | 8 | 10-to-90 rise, in samples |
| fallOut | output | 8 | 90-to-10 fall, in samples |
| widthBad | output | 1 | Width crossing missing |
| riseBad | output | 1 | Rise crossing missing |
| fallBad | output | 1 | Fall crossing missing |
| avgOut | output | 8 | Window average |

## Verification
The hardest cases to reach from the ports are the records where a crossing never happens. Examples are a pulse that stays high to the end of the record, a flat record, and a baseline set above every sample. In the first two the falling side never crosses; in the last the rising side never reaches its threshold. Directed records build each of these shapes on purpose. A separate record of 260 samples overruns the buffer, which also checks that the drop-and-wait behaviour sets the done latency to 256. Random pulses with varied ramps, noise, input gaps and window settings, including windows that run past the record end, cover the ordinary cases.

// File: rtl/pulse_meas_pkg.sv
package pulse_meas_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // new record: reset pass-1 state, capture configuration
    logic store;   // write the incoming sample at idx
    logic scan;    // pass 2: examine stored sample at idx
    logic finish;  // last scan cycle: register results
  } ctrl_strb_t;
endpackage

// File: rtl/pulse_meas_ctrl.sv
module pulse_meas_ctrl
  import pulse_meas_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startIn,
  input  logic          sampleValid,
  input  logic          sampleLast,
  output ctrl_strb_t    strb,
  output logic [AW-1:0] idx
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SCAN} state_t;

  state_t        state;
  logic [AW-1:0] lastIdx;
  logic          full;

  always_comb begin
    strb.clear  = startIn;
    strb.store  = (state == ST_LOAD) && !startIn && sampleValid && !full;
    strb.scan   = (state == ST_SCAN) && !startIn;
    strb.finish = strb.scan && (idx == lastIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      lastIdx <= '0;
      full    <= 1'b0;
    end else if (startIn) begin
      state <= ST_LOAD;
      idx   <= '0;
      full  <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: begin
          if (strb.store) begin
            lastIdx <= idx;
            if (idx == AW'(DEPTH - 1)) full <= 1'b1;
            else                       idx  <= idx + 1'b1;
          end
          if (sampleValid && sampleLast) begin
            state <= ST_SCAN;
            idx   <= '0;
          end
        end
        ST_SCAN: begin
          if (strb.finish) state <= ST_IDLE;
          else             idx   <= idx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R9: the scan pointer never passes the record end
  p_scan_in_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |-> (idx <= lastIdx));

  // R1: the buffer only saturates at its top slot
  p_full_at_top_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && full) |-> (idx == AW'(DEPTH - 1)));
endmodule

// File: rtl/pulse_meas_dp.sv
module pulse_meas_dp
  import pulse_meas_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int SW      = 8,
  parameter int MAX_LOG = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int LOGW = $clog2(MAX_LOG + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_strb_t      strb,
  input  logic [AW-1:0]   idx,
  input  logic [SW-1:0]   sampleData,
  input  logic [SW-1:0]   baseline,
  input  logic [AW-1:0]   winStart,
  input  logic [LOGW-1:0] winLog2,
  output logic            doneOut,
  output logic [SW-1:0]   peakOut,
  output logic [AW-1:0]   peakIdxOut,
  output logic [AW-1:0]   widthOut,
  output logic [AW-1:0]   riseOut,
  output logic [AW-1:0]   fallOut,
  output logic            widthBad,
  output logic            riseBad,
  output logic            fallBad,
  output logic [SW-1:0]   avgOut
);
  localparam int WL   = MAX_LOG + 1;
  localparam int OW   = AW + WL;
  localparam int SUMW = SW + MAX_LOG;
  localparam int MW   = SW + 4;
  localparam int NCR  = 6;   // 0:rise10 1:rise90 2:width-start 3:width-end 4:fall90 5:fall10
  localparam logic [NCR-1:0] POST_SEL = 6'b111000;

  logic [SW-1:0]   mem [DEPTH];
  logic [SW-1:0]   baseR;
  logic [AW-1:0]   winStartR;
  logic [LOGW-1:0] lenLog;
  logic [SW-1:0]   peakVal;
  logic [AW-1:0]   peakIdx;
  logic            peakSeen;
  logic [SUMW-1:0] sum;

  // ---------------- pass 1: store, peak, window sum ----------------
  logic [LOGW-1:0] logClamp;
  logic [OW-1:0]   winOff;
  logic            inWin;

  assign logClamp = (winLog2 > LOGW'(MAX_LOG)) ? LOGW'(MAX_LOG) : winLog2;
  assign winOff   = OW'(idx) - OW'(winStartR);
  assign inWin    = (idx >= winStartR) && (winOff < (OW'(1) << lenLog));

  always_ff @(posedge clk) begin
    if (strb.store) mem[idx] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR <= '0; winStartR <= '0; lenLog <= '0;
      peakVal <= '0; peakIdx <= '0; peakSeen <= 1'b0; sum <= '0;
    end else if (strb.clear) begin
      baseR     <= baseline;
      winStartR <= winStart;
      lenLog    <= logClamp;
      peakVal   <= '0;
      peakIdx   <= '0;
      peakSeen  <= 1'b0;
      sum       <= '0;
    end else if (strb.store) begin
      if (!peakSeen || sampleData > peakVal) begin
        peakVal  <= sampleData;
        peakIdx  <= idx;
        peakSeen <= 1'b1;
      end
      if (inWin) sum <= sum + SUMW'(sampleData);
    end
  end

  // ---------------- thresholds ----------------
  logic [SW-1:0] amp, t10, t50, t90;
  logic [MW-1:0] amp9;
  assign amp  = (peakVal > baseR) ? peakVal - baseR : '0;
  assign amp9 = MW'(amp) * MW'(9);
  assign t10  = baseR + SW'(MW'(amp) / MW'(10));
  assign t50  = baseR + (amp >> 1);
  assign t90  = baseR + SW'(amp9 / MW'(10));

  logic [SW-1:0] thr [NCR];
  always_comb begin
    thr[0] = t10; thr[1] = t90; thr[2] = t50;
    thr[3] = t50; thr[4] = t90; thr[5] = t10;
  end

  // ---------------- pass 2: crossing trackers ----------------
  logic [SW-1:0]          curS;
  logic                   postSide;
  logic [NCR-1:0]         nFnd;
  logic [NCR-1:0][AW-1:0] nPos;

  assign curS     = mem[idx];
  assign postSide = idx > peakIdx;

  for (genvar k = 0; k < NCR; k++) begin : g_cross
    logic          fndQ;
    logic [AW-1:0] posQ;
    logic          hit;
    assign hit = strb.scan && !fndQ &&
                 (POST_SEL[k] ? (postSide && curS < thr[k])
                              : (!postSide && curS >= thr[k]));
    assign nFnd[k] = fndQ | hit;
    assign nPos[k] = hit ? idx : posQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fndQ <= 1'b0; posQ <= '0;
      end else if (strb.clear) begin
        fndQ <= 1'b0;
      end else if (strb.scan) begin
        fndQ <= nFnd[k];
        posQ <= nPos[k];
      end
    end
  end

  // ---------------- results ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneOut <= 1'b0; peakOut <= '0; peakIdxOut <= '0;
      widthOut <= '0; riseOut <= '0; fallOut <= '0;
      widthBad <= 1'b0; riseBad <= 1'b0; fallBad <= 1'b0; avgOut <= '0;
    end else begin
      doneOut <= strb.finish;
      if (strb.finish) begin
        peakOut    <= peakVal;
        peakIdxOut <= peakIdx;
        riseBad    <= !(nFnd[0] && nFnd[1]);
        riseOut    <= (nFnd[0] && nFnd[1]) ? nPos[1] - nPos[0] : '1;
        widthBad   <= !(nFnd[2] && nFnd[3]);
        widthOut   <= (nFnd[2] && nFnd[3]) ? nPos[3] - nPos[2] : '1;
        fallBad    <= !(nFnd[4] && nFnd[5]);
        fallOut    <= (nFnd[4] && nFnd[5]) ? nPos[5] - nPos[4] : '1;
        avgOut     <= SW'(sum >> lenLog);
      end
    end
  end

  // R2: the running peak only grows within a record
  p_peak_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> (peakVal >= $past(peakVal)));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R7: a window average cannot exceed the peak
  p_avg_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (avgOut <= peakOut));

  // R4: both rise crossings lie at or before the peak
  p_rise_before_peak_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !riseBad) |-> (riseOut <= peakIdxOut));

  // R5: a missing width crossing shows as all ones
  p_width_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && widthBad) |-> (widthOut == '1));
endmodule

// File: rtl/pulse_param_extract.sv
module pulse_param_extract
  import pulse_meas_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int SW      = 8,
  parameter int MAX_LOG = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int LOGW = $clog2(MAX_LOG + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic            sampleValid,
  input  logic [SW-1:0]   sampleData,
  input  logic            sampleLast,
  input  logic [SW-1:0]   baseline,
  input  logic [AW-1:0]   winStart,
  input  logic [LOGW-1:0] winLog2,
  output logic            doneOut,
  output logic [SW-1:0]   peakOut,
  output logic [AW-1:0]   peakIdxOut,
  output logic [AW-1:0]   widthOut,
  output logic [AW-1:0]   riseOut,
  output logic [AW-1:0]   fallOut,
  output logic            widthBad,
  output logic            riseBad,
  output logic            fallBad,
  output logic [SW-1:0]   avgOut
);
  ctrl_strb_t    strb;
  logic [AW-1:0] idx;

  pulse_meas_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sampleValid(sampleValid),
    .sampleLast(sampleLast), .strb(strb), .idx(idx)
  );

  pulse_meas_dp #(.DEPTH(DEPTH), .SW(SW), .MAX_LOG(MAX_LOG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .sampleData(sampleData),
    .baseline(baseline), .winStart(winStart), .winLog2(winLog2),
    .doneOut(doneOut), .peakOut(peakOut), .peakIdxOut(peakIdxOut),
    .widthOut(widthOut), .riseOut(riseOut), .fallOut(fallOut),
    .widthBad(widthBad), .riseBad(riseBad), .fallBad(fallBad), .avgOut(avgOut)
  );
endmodule

// File: tb/test_pulse_param_extract.sv
module test_pulse_param_extract;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startIn = 1'b0, sampleValid = 1'b0, sampleLast = 1'b0;
  logic [7:0] sampleData = '0, baseline = '0, winStart = '0;
  logic [3:0] winLog2 = '0;
  logic       doneOut, widthBad, riseBad, fallBad;
  logic [7:0] peakOut, peakIdxOut, widthOut, riseOut, fallOut, avgOut;

  always #2 clk = ~clk;

  pulse_param_extract i_pulse_param_extract (
    .clk(clk), .rstN(rstN), .startIn(startIn), .sampleValid(sampleValid),
    .sampleData(sampleData), .sampleLast(sampleLast), .baseline(baseline),
    .winStart(winStart), .winLog2(winLog2), .doneOut(doneOut), .peakOut(peakOut),
    .peakIdxOut(peakIdxOut), .widthOut(widthOut), .riseOut(riseOut),
    .fallOut(fallOut), .widthBad(widthBad), .riseBad(riseBad),
    .fallBad(fallBad), .avgOut(avgOut)
  );

  int checks = 0, fails = 0, cyc = 0;
  int rec [0:299];
  int eBase, eWinS, eWinL;
  int ePeak, ePIdx, eWidth, eRise, eFall, eAvg, eWB, eRB, eFB;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // reference model (from the requirements)
  task automatic model(input int m);
    int amp, t10, t50, t90, a, b, len, s;
    ePeak = rec[0]; ePIdx = 0;
    for (int i = 1; i < m; i++) if (rec[i] > ePeak) begin ePeak = rec[i]; ePIdx = i; end
    amp = (ePeak > eBase) ? ePeak - eBase : 0;
    t10 = eBase + amp / 10; t50 = eBase + amp / 2; t90 = eBase + (9 * amp) / 10;
    // rise
    a = -1; b = -1;
    for (int i = 0; i <= ePIdx; i++) begin
      if (a < 0 && rec[i] >= t10) a = i;
      if (b < 0 && rec[i] >= t90) b = i;
    end
    eRB = (a < 0 || b < 0); eRise = eRB ? 255 : b - a;
    // width
    a = -1; b = -1;
    for (int i = 0; i <= ePIdx; i++) if (a < 0 && rec[i] >= t50) a = i;
    for (int i = ePIdx + 1; i < m; i++) if (b < 0 && rec[i] < t50) b = i;
    eWB = (a < 0 || b < 0); eWidth = eWB ? 255 : b - a;
    // fall
    a = -1; b = -1;
    for (int i = ePIdx + 1; i < m; i++) begin
      if (a < 0 && rec[i] < t90) a = i;
      if (b < 0 && rec[i] < t10) b = i;
    end
    eFB = (a < 0 || b < 0); eFall = eFB ? 255 : b - a;
    // average
    len = 1 << ((eWinL > 10) ? 10 : eWinL);
    s = 0;
    for (int i = eWinS; i < eWinS + len; i++) if (i < m) s += rec[i];
    eAvg = s / len;
  endtask

  task automatic genPulse(input int n, input int base, input int pk, input int amp,
                          input int rl, input int fl, input int noise);
    for (int i = 0; i < n; i++) begin
      int v = base;
      if (i <= pk && i > pk - rl) v = base + amp * (i - (pk - rl)) / rl;
      else if (i > pk && i < pk + fl) v = base + amp * (pk + fl - i) / fl;
      v += (noise > 0) ? $urandom_range(0, noise) : 0;
      rec[i] = (v > 255) ? 255 : v;
    end
  endtask

  // sends rec[0..n-1]; checks latency and all results
  task automatic runRecord(input int n, input int gapPct, input bit scramble,
                           input string tag);
    int lat, m;
    bit seen;
    m = (n > DEPTH) ? DEPTH : n;
    @(negedge clk);
    startIn = 1'b1; baseline = 8'(eBase); winStart = 8'(eWinS); winLog2 = 4'(eWinL);
    @(negedge clk);
    startIn = 1'b0;
    if (scramble) begin  // R8: later config changes must not matter
      baseline = 8'($urandom_range(0, 255)); winStart = 8'($urandom_range(0, 255));
      winLog2 = 4'($urandom_range(0, 15));
    end
    for (int i = 0; i < n; i++) begin
      while ($urandom_range(0, 99) < gapPct) begin
        sampleValid = 1'b0; sampleData = 8'hFF; @(negedge clk);
      end
      sampleValid = 1'b1; sampleData = 8'(rec[i]); sampleLast = (i == n - 1);
      if (i < n - 1) @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0; sampleLast = 1'b0;
    if (doneOut) chk(1'b0, "R9", {tag, " early done"}, 1, 0);
    lat = 0; seen = 0;
    while (!seen && lat < 400) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (doneOut) seen = 1;
    end
    model(m);
    chk(lat == m, "R9", {tag, " done latency"}, lat, m);
    chk(peakOut == ePeak, "R2", {tag, " peak"}, peakOut, ePeak);
    chk(peakIdxOut == ePIdx, "R2", {tag, " peak index"}, peakIdxOut, ePIdx);
    chk(riseOut == eRise && riseBad == eRB, "R4", {tag, " rise"}, riseOut, eRise);
    chk(widthOut == eWidth && widthBad == eWB, "R5", {tag, " width"}, widthOut, eWidth);
    chk(fallOut == eFall && fallBad == eFB, "R6", {tag, " fall"}, fallOut, eFall);
    chk(avgOut == eAvg, "R7", {tag, " average"}, avgOut, eAvg);
    @(negedge clk);
    chk(!doneOut && peakOut == ePeak && avgOut == eAvg, "R9",
        {tag, " done pulse and hold"}, doneOut, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!doneOut && peakOut == 0 && widthOut == 0 && riseOut == 0 && fallOut == 0 &&
        avgOut == 0 && !widthBad && !riseBad && !fallBad, "R10", "reset state", doneOut, 0);
    rstN = 1'b1;

    // R1: samples with no open record are ignored
    @(negedge clk); sampleValid = 1'b1; sampleData = 8'd250;
    repeat (4) @(negedge clk); sampleValid = 1'b0;

    // triangle pulse (R3 R4 R5 R6)
    eBase = 10; eWinS = 5; eWinL = 3;
    genPulse(40, 10, 15, 100, 8, 12, 0);
    runRecord(40, 0, 0, "triangle");

    // R1 restart: stray samples before a new start are discarded
    @(negedge clk); startIn = 1'b1; @(negedge clk); startIn = 1'b0;
    sampleValid = 1'b1; sampleData = 8'd254; repeat (3) @(negedge clk); sampleValid = 1'b0;
    eBase = 0; eWinS = 0; eWinL = 2;
    genPulse(30, 5, 10, 80, 4, 6, 0);
    runRecord(30, 0, 0, "restart");

    // peak at index 0 (R4 rise of zero)
    for (int i = 0; i < 20; i++) rec[i] = 200 - 9 * i;
    eBase = 0; eWinS = 0; eWinL = 0;
    runRecord(20, 0, 0, "peak-first");

    // pulse that never falls (R5 R6 invalid)
    for (int i = 0; i < 25; i++) rec[i] = (i < 5) ? 20 : 180;
    eBase = 20; eWinS = 3; eWinL = 4;
    runRecord(25, 0, 0, "no-fall");

    // flat record (amplitude zero, ties resolved to lowest index)
    for (int i = 0; i < 16; i++) rec[i] = 60;
    eBase = 60; eWinS = 0; eWinL = 4;
    runRecord(16, 0, 0, "flat");

    // baseline above everything: rising crossings missing (R4)
    genPulse(24, 30, 12, 40, 5, 5, 0);
    eBase = 200; eWinS = 20; eWinL = 3;
    runRecord(24, 0, 0, "high-base");

    // overflow: 260 samples, 256 stored (R1 R9)
    genPulse(260, 12, 100, 150, 20, 30, 3);
    rec[258] = 255;
    eBase = 12; eWinS = 250; eWinL = 4;
    runRecord(260, 0, 0, "overflow");

    // window length clamp and window past end (R7), config scramble (R8)
    genPulse(50, 8, 20, 120, 6, 10, 2);
    eBase = 8; eWinS = 10; eWinL = 15;
    runRecord(50, 20, 1, "clamp-scramble");

    // random pulses
    for (int t = 0; t < 40; t++) begin
      int n, pk;
      n = $urandom_range(4, 150);
      pk = $urandom_range(0, n - 1);
      eBase = $urandom_range(0, 60);
      genPulse(n, eBase, pk, $urandom_range(10, 190), $urandom_range(1, 15),
               $urandom_range(1, 20), $urandom_range(0, 6));
      eWinS = $urandom_range(0, n); eWinL = $urandom_range(0, 11);
      runRecord(n, $urandom_range(0, 30), t[0], "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule